// File: doc/BRIEF.md
# Data-Processing Execute Unit with Condition Flags

This unit carries out the sixteen register-to-register data-processing operations of a 32-bit RISC core. It receives the first operand from the register file and a second operand that has already passed through the barrel shifter. With them it receives the shifter's carry-out, the current condition flags, a flag-update request bit, the destination register index and a user-mode indication. It produces the result, a register write strobe and the next condition flags. It also raises one of two signals when a flag-setting write targets the program counter: a request to return from an exception, or an illegal-instruction indication when the core runs unprivileged.

All outputs are registered. An operation presented with `in_valid` high at a rising edge appears on the outputs one cycle later, qualified by `out_valid`. Flags are packed as {N, Z, C, V}, with N at bit 3 and V at bit 0. The caller feeds `flags_out` back to `flags_in` as its flag state. The opcode encoding is: 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, A CMP, B CMN, C ORR, D MOV, E BIC, F MVN.

Top module: `dp_alu`

## Requirements
- R1: The logical opcodes give these results: AND (0) rn&op2, EOR (1) rn^op2, ORR (C) rn|op2, BIC (E) rn&~op2, MOV (D) op2, MVN (F) ~op2. MOV and MVN ignore rn.
- R2: ADD (4) gives rn+op2, SUB (2) gives rn-op2 and RSB (3) gives op2-rn, all modulo 2^32.
- R3: ADC (5) gives rn+op2+C, SBC (6) gives rn-op2-(1-C) and RSC (7) gives op2-rn-(1-C). C is flags_in bit 1.
- R4: TST, TEQ, CMP and CMN (opcodes 8 to B) never raise wr_en. They change the flags only when set_flags is high.
- R5: A flag-setting logical opcode (0, 1, 8, 9, C, D, E, F) sets N to result bit 31, sets Z when the result is zero, copies shift_cout into C and keeps V from flags_in.
- R6: A flag-setting arithmetic opcode (2 to 7, A, B) takes N, Z, C and V from the adder. For subtraction C is 1 when no borrow occurs.
- R7: With set_flags low, flags_out equals flags_in, and every opcode outside 8 to B raises wr_en.
- R8: SUB or MOV with set_flags high and dest_idx 15 in privileged mode raises exc_return, keeps wr_en low and leaves the flags unchanged. Other opcodes writing index 15 write normally.
- R9: The same SUB or MOV case in user mode raises illegal, keeps exc_return and wr_en low and leaves the flags unchanged.
- R10: Outputs follow an accepted operation by exactly one cycle. A cycle with in_valid low leaves out_valid, wr_en, exc_return and illegal low on the next cycle and holds result and flags_out.
- R11: After a synchronous active-low reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Data-processing opcode |
| rn_val | input | 32 | First operand |
| op2_val | input | 32 | Shifted second operand |
| shift_cout | input | 1 | Carry-out of the shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | Flag-update request bit |
| dest_idx | input | 4 | Destination register index |
| user_mode | input | 1 | Core is in unprivileged mode |
| out_valid | output | 1 | Outputs belong to an accepted operation |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Write result to dest register |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| exc_return | output | 1 | Exception return requested |
| illegal | output | 1 | Instruction is illegal in this mode |

## Verification
Every result, the write strobe, the flags and both status signals come out of one register stage, so each is due one rising edge after the cycle that presents the operation. The bench drives each operation on a falling edge, waits for the next falling edge, and reads every output there, half a period after the capturing edge. It then drops in_valid and checks the following idle cycle, which shows that the qualifiers clear while result and flags hold.

// File: rtl/dp_alu_pkg.sv
// Package: shared opcode type, flag bit positions and opcode-class helpers
// for the data-processing execute unit.
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } dp_op_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;
    localparam int FLAG_W = 4;

    // True for opcodes whose flags come from the logic path
    function automatic logic is_logic_op(input logic [3:0] op);
        return (op[2:1] == 2'b00) || (op[3:2] == 2'b11);
    endfunction

    // True for the compare-only group that never writes a register
    function automatic logic is_compare_op(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

endpackage

// File: rtl/dp_adder.sv
// Module: dp_adder
// Shared adder for all arithmetic opcodes. Picks the operand order, the
// inversion and the carry-in from the opcode, then adds once.
// Assumes: opcode is an arithmetic one; for logic opcodes the outputs are
// computed but unused.
module dp_adder
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] rn,
    input  logic [WIDTH-1:0] op2,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_out,
    output logic             v_out
);

    localparam int SUM_W = WIDTH + 1;

    logic [WIDTH-1:0] a_opd;
    logic [WIDTH-1:0] b_opd;
    logic             cin_sel;
    logic [SUM_W-1:0] full;

    // Operand order, inversion and carry-in per opcode
    always_comb begin
        a_opd   = rn;
        b_opd   = op2;
        cin_sel = 1'b0;
        case (dp_op_e'(op))
            OP_SUB, OP_CMP: begin b_opd = ~op2; cin_sel = 1'b1;  end
            OP_RSB:         begin a_opd = op2; b_opd = ~rn; cin_sel = 1'b1; end
            OP_ADC:         begin cin_sel = c_in;                end
            OP_SBC:         begin b_opd = ~op2; cin_sel = c_in;  end
            OP_RSC:         begin a_opd = op2; b_opd = ~rn; cin_sel = c_in; end
            default:        begin cin_sel = 1'b0;                end
        endcase
    end

    // Single carry-propagate addition
    always_comb begin
        full = {1'b0, a_opd} + {1'b0, b_opd} + {{WIDTH{1'b0}}, cin_sel};
    end

    // Carry and signed-overflow extraction
    always_comb begin
        sum   = full[WIDTH-1:0];
        c_out = full[WIDTH];
        v_out = (a_opd[WIDTH-1] == b_opd[WIDTH-1]) &&
                (full[WIDTH-1] != a_opd[WIDTH-1]);
    end

endmodule

// File: rtl/dp_logic.sv
// Module: dp_logic
// Bitwise path for the logical opcodes, including test forms.
// Assumes: op2 already carries any shift.
module dp_logic
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] rn,
    input  logic [WIDTH-1:0] op2,
    output logic [WIDTH-1:0] res
);

    // Bitwise operation per opcode
    always_comb begin
        case (dp_op_e'(op))
            OP_AND, OP_TST: res = rn & op2;
            OP_EOR, OP_TEQ: res = rn ^ op2;
            OP_ORR:         res = rn | op2;
            OP_MOV:         res = op2;
            OP_BIC:         res = rn & ~op2;
            OP_MVN:         res = ~op2;
            default:        res = '0;
        endcase
    end

endmodule

// File: rtl/dp_ctrl.sv
// Module: dp_ctrl
// Decodes write-back, flag update and program-counter return handling.
// Assumes: the program counter is the highest register index.
module dp_ctrl
    import dp_alu_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [3:0]       op,
    input  logic             set_flags,
    input  logic [IDX_W-1:0] dest,
    input  logic             user_mode,
    output logic             wr_req,
    output logic             flag_upd,
    output logic             exc_req,
    output logic             ill_req,
    output logic             use_logic
);

    localparam logic [IDX_W-1:0] PC_IDX = {IDX_W{1'b1}};

    logic ret_form;

    // Flag-setting SUB or MOV aimed at the program counter
    always_comb begin
        ret_form = set_flags && (dest == PC_IDX) &&
                   ((dp_op_e'(op) == OP_SUB) || (dp_op_e'(op) == OP_MOV));
    end

    // Control outputs
    always_comb begin
        exc_req   = ret_form && !user_mode;
        ill_req   = ret_form && user_mode;
        wr_req    = !is_compare_op(op) && !ret_form;
        flag_upd  = set_flags && !ret_form;
        use_logic = is_logic_op(op);
    end

endmodule

// File: rtl/dp_alu.sv
// Module: dp_alu (top)
// Data-processing execute unit: selects the logic or adder path, forms the
// next flags and registers all outputs one cycle after in_valid.
// Assumes: flags packed {N,Z,C,V}; synchronous active-low reset.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        opcode,
    input  logic [WIDTH-1:0]  rn_val,
    input  logic [WIDTH-1:0]  op2_val,
    input  logic              shift_cout,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              set_flags,
    input  logic [IDX_W-1:0]  dest_idx,
    input  logic              user_mode,
    output logic              out_valid,
    output logic [WIDTH-1:0]  result,
    output logic              wr_en,
    output logic [FLAG_W-1:0] flags_out,
    output logic              exc_return,
    output logic              illegal
);

    logic [WIDTH-1:0]  add_sum;
    logic              add_c;
    logic              add_v;
    logic [WIDTH-1:0]  log_res;
    logic              wr_req;
    logic              flag_upd;
    logic              exc_req;
    logic              ill_req;
    logic              use_logic;
    logic [WIDTH-1:0]  res_nx;
    logic [FLAG_W-1:0] flags_nx;

    dp_adder #(.WIDTH(WIDTH)) u_add (
        .op    (opcode),
        .rn    (rn_val),
        .op2   (op2_val),
        .c_in  (flags_in[FLAG_C]),
        .sum   (add_sum),
        .c_out (add_c),
        .v_out (add_v)
    );

    dp_logic #(.WIDTH(WIDTH)) u_log (
        .op  (opcode),
        .rn  (rn_val),
        .op2 (op2_val),
        .res (log_res)
    );

    dp_ctrl #(.IDX_W(IDX_W)) u_ctl (
        .op        (opcode),
        .set_flags (set_flags),
        .dest      (dest_idx),
        .user_mode (user_mode),
        .wr_req    (wr_req),
        .flag_upd  (flag_upd),
        .exc_req   (exc_req),
        .ill_req   (ill_req),
        .use_logic (use_logic)
    );

    // Result path select
    always_comb begin
        res_nx = use_logic ? log_res : add_sum;
    end

    // Next-flag formation
    always_comb begin
        flags_nx = flags_in;
        if (flag_upd) begin
            flags_nx[FLAG_N] = res_nx[WIDTH-1];
            flags_nx[FLAG_Z] = (res_nx == '0);
            if (use_logic) begin
                flags_nx[FLAG_C] = shift_cout;
            end else begin
                flags_nx[FLAG_C] = add_c;
                flags_nx[FLAG_V] = add_v;
            end
        end
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            wr_en      <= 1'b0;
            flags_out  <= '0;
            exc_return <= 1'b0;
            illegal    <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            wr_en      <= in_valid && wr_req;
            exc_return <= in_valid && exc_req;
            illegal    <= in_valid && ill_req;
            if (in_valid) begin
                result    <= res_nx;
                flags_out <= flags_nx;
            end
        end
    end

endmodule

// File: rtl/dp_alu_chk.sv
// Module: dp_alu_chk
// Property checker bound to dp_alu; observes its ports only.
module dp_alu_chk
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IDX_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        opcode,
    input logic [WIDTH-1:0]  rn_val,
    input logic [WIDTH-1:0]  op2_val,
    input logic              shift_cout,
    input logic [FLAG_W-1:0] flags_in,
    input logic              set_flags,
    input logic [IDX_W-1:0]  dest_idx,
    input logic              user_mode,
    input logic              out_valid,
    input logic [WIDTH-1:0]  result,
    input logic              wr_en,
    input logic [FLAG_W-1:0] flags_out,
    input logic              exc_return,
    input logic              illegal
);

    localparam logic [IDX_W-1:0] PC_IDX = {IDX_W{1'b1}};

    // R4
    compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[3:2] == 2'b10) |=> !wr_en);

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !set_flags) |=> (flags_out == $past(flags_in)));

    // R5
    logic_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && is_logic_op(opcode)) |=>
        (flags_out[FLAG_V] == $past(flags_in[FLAG_V])));

    // R9
    user_return_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && user_mode && dest_idx == PC_IDX &&
         (opcode == 4'h2 || opcode == 4'hD)) |=> (illegal && !exc_return && !wr_en));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && !exc_return && !illegal));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flags_out)));

    // R8
    return_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_return, illegal, wr_en}));

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .opcode     (opcode),
    .rn_val     (rn_val),
    .op2_val    (op2_val),
    .shift_cout (shift_cout),
    .flags_in   (flags_in),
    .set_flags  (set_flags),
    .dest_idx   (dest_idx),
    .user_mode  (user_mode),
    .out_valid  (out_valid),
    .result     (result),
    .wr_en      (wr_en),
    .flags_out  (flags_out),
    .exc_return (exc_return),
    .illegal    (illegal)
);

// File: tb/sim_dp_alu.sv
// Directed bench for dp_alu: one task per scenario, each checking its results.
module sim_dp_alu;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  opcode;
    logic [31:0] rn_val;
    logic [31:0] op2_val;
    logic        shift_cout;
    logic [3:0]  flags_in;
    logic        set_flags;
    logic [3:0]  dest_idx;
    logic        user_mode;
    logic        out_valid;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  flags_out;
    logic        exc_return;
    logic        illegal;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .rn_val(rn_val), .op2_val(op2_val), .shift_cout(shift_cout),
        .flags_in(flags_in), .set_flags(set_flags), .dest_idx(dest_idx),
        .user_mode(user_mode), .out_valid(out_valid), .result(result),
        .wr_en(wr_en), .flags_out(flags_out), .exc_return(exc_return),
        .illegal(illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Present one operation at a falling edge; outputs are read one edge later
    task automatic issue(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic sc,
                         input logic [3:0] fl, input logic s,
                         input logic [3:0] rd, input logic usr);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; rn_val = a; op2_val = b;
        shift_cout = sc; flags_in = fl; set_flags = s; dest_idx = rd;
        user_mode = usr;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [31:0] res,
                              input logic we, input logic [3:0] fl,
                              input logic exc, input logic ill);
        chk(req, "out_valid", {31'b0, out_valid}, 32'd1);
        chk(req, "result", result, res);
        chk(req, "wr_en", {31'b0, wr_en}, {31'b0, we});
        chk(req, "flags", {28'b0, flags_out}, {28'b0, fl});
        chk(req, "exc_return", {31'b0, exc_return}, {31'b0, exc});
        chk(req, "illegal", {31'b0, illegal}, {31'b0, ill});
    endtask

    task automatic test_reset();
        rst_n = 1'b0; in_valid = 1'b0; opcode = '0; rn_val = '0; op2_val = '0;
        shift_cout = 1'b0; flags_in = '0; set_flags = 1'b0; dest_idx = '0;
        user_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 all outputs zero after reset
        chk("R11", "out_valid", {31'b0, out_valid}, 32'd0);
        chk("R11", "result", result, 32'd0);
        chk("R11", "wr_en", {31'b0, wr_en}, 32'd0);
        chk("R11", "flags", {28'b0, flags_out}, 32'd0);
        chk("R11", "exc/ill", {30'b0, exc_return, illegal}, 32'd0);
    endtask

    task automatic test_logic();
        // R1 bitwise results, flags untouched with S clear (R7)
        issue(4'h0, 32'hF0F0_00FF, 32'h0FF0_0F0F, 1'b1, 4'b0101, 1'b0, 4'd1, 1'b0);
        expect_out("R1", 32'h00F0_000F, 1'b1, 4'b0101, 1'b0, 1'b0);
        issue(4'h1, 32'hF0F0_00FF, 32'h0FF0_0F0F, 1'b1, 4'b0101, 1'b0, 4'd1, 1'b0);
        expect_out("R1", 32'hFF00_0FF0, 1'b1, 4'b0101, 1'b0, 1'b0);
        issue(4'hC, 32'hF0F0_00FF, 32'h0FF0_0F0F, 1'b1, 4'b0101, 1'b0, 4'd1, 1'b0);
        expect_out("R1", 32'hFFF0_0FFF, 1'b1, 4'b0101, 1'b0, 1'b0);
        issue(4'hE, 32'hF0F0_00FF, 32'h0FF0_0F0F, 1'b1, 4'b0101, 1'b0, 4'd1, 1'b0);
        expect_out("R1", 32'hF000_00F0, 1'b1, 4'b0101, 1'b0, 1'b0);
        issue(4'hD, 32'hF0F0_00FF, 32'h0FF0_0F0F, 1'b1, 4'b0101, 1'b0, 4'd1, 1'b0);
        expect_out("R1", 32'h0FF0_0F0F, 1'b1, 4'b0101, 1'b0, 1'b0);
        issue(4'hF, 32'hF0F0_00FF, 32'h0FF0_0F0F, 1'b1, 4'b0101, 1'b0, 4'd1, 1'b0);
        expect_out("R1", 32'hF00F_F0F0, 1'b1, 4'b0101, 1'b0, 1'b0);
    endtask

    task automatic test_arith();
        // R2 plain add and subtract forms, R7 flags kept
        issue(4'h4, 32'd5, 32'd3, 1'b0, 4'b1010, 1'b0, 4'd2, 1'b0);
        expect_out("R2", 32'd8, 1'b1, 4'b1010, 1'b0, 1'b0);
        issue(4'h2, 32'd5, 32'd3, 1'b0, 4'b1010, 1'b0, 4'd2, 1'b0);
        expect_out("R2", 32'd2, 1'b1, 4'b1010, 1'b0, 1'b0);
        issue(4'h3, 32'd5, 32'd3, 1'b0, 4'b1010, 1'b0, 4'd2, 1'b0);
        expect_out("R2", 32'hFFFF_FFFE, 1'b1, 4'b1010, 1'b0, 1'b0);
    endtask

    task automatic test_carry_in();
        // R3 carry-in taken from flags_in bit 1
        issue(4'h5, 32'd5, 32'd3, 1'b0, 4'b0010, 1'b0, 4'd2, 1'b0);
        expect_out("R3", 32'd9, 1'b1, 4'b0010, 1'b0, 1'b0);
        issue(4'h5, 32'd5, 32'd3, 1'b0, 4'b0000, 1'b0, 4'd2, 1'b0);
        expect_out("R3", 32'd8, 1'b1, 4'b0000, 1'b0, 1'b0);
        issue(4'h6, 32'd5, 32'd3, 1'b0, 4'b0010, 1'b0, 4'd2, 1'b0);
        expect_out("R3", 32'd2, 1'b1, 4'b0010, 1'b0, 1'b0);
        issue(4'h6, 32'd5, 32'd3, 1'b0, 4'b0000, 1'b0, 4'd2, 1'b0);
        expect_out("R3", 32'd1, 1'b1, 4'b0000, 1'b0, 1'b0);
        issue(4'h7, 32'd3, 32'd5, 1'b0, 4'b0000, 1'b0, 4'd2, 1'b0);
        expect_out("R3", 32'd1, 1'b1, 4'b0000, 1'b0, 1'b0);
    endtask

    task automatic test_arith_flags();
        // R6 adder flags {N,Z,C,V}
        issue(4'h4, 32'h7FFF_FFFF, 32'd1, 1'b0, 4'b0000, 1'b1, 4'd4, 1'b0);
        expect_out("R6", 32'h8000_0000, 1'b1, 4'b1001, 1'b0, 1'b0);
        issue(4'h2, 32'd5, 32'd5, 1'b0, 4'b0000, 1'b1, 4'd4, 1'b0);
        expect_out("R6", 32'd0, 1'b1, 4'b0110, 1'b0, 1'b0);
        issue(4'h2, 32'd3, 32'd5, 1'b0, 4'b0111, 1'b1, 4'd4, 1'b0);
        expect_out("R6", 32'hFFFF_FFFE, 1'b1, 4'b1000, 1'b0, 1'b0);
        issue(4'h4, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b0000, 1'b1, 4'd4, 1'b0);
        expect_out("R6", 32'd0, 1'b1, 4'b0110, 1'b0, 1'b0);
    endtask

    task automatic test_compare();
        // R4 compare group: no write, flags only with S
        issue(4'h8, 32'hF0, 32'h0F, 1'b1, 4'b1010, 1'b0, 4'd5, 1'b0);
        expect_out("R4", 32'd0, 1'b0, 4'b1010, 1'b0, 1'b0);
        issue(4'h8, 32'hF0, 32'h0F, 1'b1, 4'b1001, 1'b1, 4'd5, 1'b0);
        expect_out("R4", 32'd0, 1'b0, 4'b0111, 1'b0, 1'b0);
        issue(4'h9, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0000, 1'b1, 4'd5, 1'b0);
        expect_out("R4", 32'd0, 1'b0, 4'b0100, 1'b0, 1'b0);
        issue(4'hA, 32'h8000_0000, 32'd1, 1'b0, 4'b0000, 1'b1, 4'd5, 1'b0);
        expect_out("R4", 32'h7FFF_FFFF, 1'b0, 4'b0011, 1'b0, 1'b0);
        issue(4'hB, 32'd1, 32'hFFFF_FFFF, 1'b0, 4'b0000, 1'b1, 4'd5, 1'b0);
        expect_out("R4", 32'd0, 1'b0, 4'b0110, 1'b0, 1'b0);
    endtask

    task automatic test_logic_flags();
        // R5 logical flags: C from shifter, V kept
        issue(4'hD, 32'h1234_5678, 32'h8000_0000, 1'b1, 4'b0001, 1'b1, 4'd3, 1'b0);
        expect_out("R5", 32'h8000_0000, 1'b1, 4'b1011, 1'b0, 1'b0);
        issue(4'h0, 32'hFF00, 32'h00FF, 1'b0, 4'b1110, 1'b1, 4'd3, 1'b0);
        expect_out("R5", 32'd0, 1'b1, 4'b0100, 1'b0, 1'b0);
    endtask

    task automatic test_pc_return();
        // R8 privileged return forms and normal writes to index 15
        issue(4'h2, 32'd10, 32'd4, 1'b0, 4'b1001, 1'b1, 4'd15, 1'b0);
        expect_out("R8", 32'd6, 1'b0, 4'b1001, 1'b1, 1'b0);
        issue(4'hD, 32'd0, 32'h100, 1'b0, 4'b0110, 1'b1, 4'd15, 1'b0);
        expect_out("R8", 32'h100, 1'b0, 4'b0110, 1'b1, 1'b0);
        issue(4'h4, 32'd1, 32'd2, 1'b0, 4'b1111, 1'b1, 4'd15, 1'b0);
        expect_out("R8", 32'd3, 1'b1, 4'b0000, 1'b0, 1'b0);
        issue(4'h2, 32'd10, 32'd4, 1'b0, 4'b1001, 1'b0, 4'd15, 1'b0);
        expect_out("R8", 32'd6, 1'b1, 4'b1001, 1'b0, 1'b0);
    endtask

    task automatic test_user_illegal();
        // R9 user-mode return forms are illegal
        issue(4'h2, 32'd10, 32'd4, 1'b0, 4'b0101, 1'b1, 4'd15, 1'b1);
        chk("R9", "illegal", {31'b0, illegal}, 32'd1);
        chk("R9", "exc_return", {31'b0, exc_return}, 32'd0);
        chk("R9", "wr_en", {31'b0, wr_en}, 32'd0);
        chk("R9", "flags", {28'b0, flags_out}, 32'h5);
        issue(4'hD, 32'd0, 32'h40, 1'b1, 4'b1010, 1'b1, 4'd15, 1'b1);
        chk("R9", "illegal", {31'b0, illegal}, 32'd1);
        chk("R9", "exc_return", {31'b0, exc_return}, 32'd0);
        chk("R9", "wr_en", {31'b0, wr_en}, 32'd0);
        chk("R9", "flags", {28'b0, flags_out}, 32'hA);
    endtask

    task automatic test_idle();
        // R10 one-cycle latency, quiet and holding on idle cycles
        issue(4'h4, 32'd20, 32'd22, 1'b0, 4'b0000, 1'b1, 4'd6, 1'b0);
        expect_out("R10", 32'd42, 1'b1, 4'b0000, 1'b0, 1'b0);
        rn_val = 32'hDEAD; flags_in = 4'b1111;
        @(negedge clk);
        chk("R10", "out_valid idle", {31'b0, out_valid}, 32'd0);
        chk("R10", "wr_en idle", {31'b0, wr_en}, 32'd0);
        chk("R10", "result hold", result, 32'd42);
        chk("R10", "flags hold", {28'b0, flags_out}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_logic();
        test_arith();
        test_carry_in();
        test_arith_flags();
        test_compare();
        test_logic_flags();
        test_pc_return();
        test_user_illegal();
        test_idle();
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule